// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block produces the internal reset of a small microcontroller core from two sources: a power-on pulse and an active-low external master-clear pin. The power-on pulse sets a reset latch and clears a start-up timer. The timer runs on the free-running oscillator clock, and it advances only while the synchronized master-clear pin reads high. When the timer reaches its programmed length it clears the latch, the internal reset ends, and a one-cycle time-out flag marks that moment.

The master-clear pin first passes through a synchronizer. If the pin drops at any time, reset is forced again and the timer starts from zero. Once the pin rises again, a full start-up delay must elapse before the reset ends. After a time-out the timer holds at its terminal count, so it cannot wrap into a second reset. A sticky flag records that a power-on event took place and stays set until software clears it.

The power-on input works asynchronously and its high level is the event. When it falls, the reset is not released. A falling supply is not an event. Only the power-on input raises the latch.

Top module: `por_reset_seq`

## Requirements
- R1: While `por_in` is high, `rst_out` is 1, `tmo_pulse` is 0 and `por_flag` is 1, whatever the levels of `mclr_n` and `por_flag_clr`.
- R2: When `por_in` falls and `mclr_n` stays low, `rst_out` remains 1 for as long as `mclr_n` stays low.
- R3: Take `mclr_n` high before rising edge 1 with the timer cleared. `rst_out` is then 1 after each of rising edges 1 to SYNC_STAGES+TMO_TICKS-1 and is 0 after rising edge SYNC_STAGES+TMO_TICKS.
- R4: Suppose `mclr_n` goes low before rising edge 1. Then `rst_out` is 1 after rising edge SYNC_STAGES and stays 1 while the pin is low. The next rise of `mclr_n` again needs the full R3 delay, even if the earlier count was partly done.
- R5: `tmo_pulse` is 1 for exactly one cycle per time-out. That cycle is the first cycle in which the reset latch is clear, and it is the cycle in which `rst_out` first reads 0 when `mclr_n` stays high.
- R6: After a time-out with `mclr_n` held high, `rst_out` stays 0 and `tmo_pulse` stays 0 indefinitely, so the timer does not wrap.
- R7: `por_flag` is set by `por_in` and survives time-outs. `por_flag_clr` high at a rising edge clears it. It then stays 0 until the next `por_in`, and this holds even when the clear lands on the time-out edge.
- R8: Let `mclr_n` be high for exactly N rising edges after a clean start. A time-out pulse occurs if and only if N >= TMO_TICKS. `rst_out` is ever seen at 0 if and only if N >= TMO_TICKS+1. A synchronized low that reaches the timer at its expiry edge wins.
- R9: `por_in` rising while the core runs sets `rst_out` and `por_flag` at once, without waiting for a clock edge. After it falls with `mclr_n` high, the full R3 delay applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| por_in | input | 1 | Power-on event, active high, asynchronous |
| mclr_n | input | 1 | External master-clear pin, active low, asynchronous |
| por_flag_clr | input | 1 | Software clear of the sticky power-on flag |
| rst_out | output | 1 | Internal chip reset, active high |
| tmo_pulse | output | 1 | One-cycle marker of the timer time-out |
| por_flag | output | 1 | Sticky power-on indication |

## Verification
Two events can meet on one clock edge. The first is the timer reaching its expiry. The second is either the synchronized master-clear low reaching the timer, or a software flag clear. The bench sweeps how long the pin stays high, from one edge up to past the expiry edge. For each length it computes from the synchronizer depth and time-out whether a pulse and a released reset must appear, and it requires the pin's low to win when both arrive together. A separate run places the flag clear on the expiry edge and expects both the clear and the pulse to take effect.

// File: rtl/por_seq_pkg.sv
`timescale 1ns/1ps
package por_seq_pkg;
  function automatic int unsigned count_width(input int unsigned ticks);
    return (ticks < 2) ? 1 : $clog2(ticks + 1);
  endfunction

  function automatic int unsigned release_edges(input int unsigned sync_stages,
                                                input int unsigned ticks);
    return sync_stages + ticks;
  endfunction
endpackage

// File: rtl/por_seq_sync.sv
`timescale 1ns/1ps
module por_seq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) sh_q <= '0;
    else      sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/por_seq_timer.sv
`timescale 1ns/1ps
module por_seq_timer #(
  parameter int unsigned TMO_TICKS = 8,
  parameter int unsigned CW        = 4
) (
  input  logic          clk,
  input  logic          arst,
  input  logic          run,
  output logic [CW-1:0] cnt_o,
  output logic          hit_o
);
  localparam logic [CW-1:0] TERM = CW'(TMO_TICKS);
  localparam logic [CW-1:0] LAST = CW'(TMO_TICKS - 1);

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c);
    return (c == TERM) ? TERM : c + 1'b1;
  endfunction

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)      cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else           cnt_q <= next_count(cnt_q);
  end

  assign cnt_o = cnt_q;
  assign hit_o = run && (cnt_q == LAST);
endmodule

// File: rtl/por_seq_state.sv
`timescale 1ns/1ps
module por_seq_state (
  input  logic clk,
  input  logic arst,
  input  logic run,
  input  logic hit,
  input  logic flag_clr,
  output logic rst_q,
  output logic tmo_q,
  output logic flag_q
);
  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      rst_q  <= 1'b1;
      tmo_q  <= 1'b0;
      flag_q <= 1'b1;
    end else begin
      tmo_q <= hit;
      if (!run)     rst_q <= 1'b1;
      else if (hit) rst_q <= 1'b0;
      if (flag_clr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/por_reset_seq.sv
`timescale 1ns/1ps
module por_reset_seq #(
  parameter int unsigned TMO_TICKS   = 72000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_in,
  input  logic mclr_n,
  input  logic por_flag_clr,
  output logic rst_out,
  output logic tmo_pulse,
  output logic por_flag
);
  localparam int unsigned CW = por_seq_pkg::count_width(TMO_TICKS);

  logic          mclr_s;
  logic [CW-1:0] cnt_q;
  logic          tmo_hit;
  logic          rst_q;

  por_seq_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .arst(por_in), .d(mclr_n), .q(mclr_s)
  );

  por_seq_timer #(.TMO_TICKS(TMO_TICKS), .CW(CW)) timer_i (
    .clk(clk), .arst(por_in), .run(mclr_s), .cnt_o(cnt_q), .hit_o(tmo_hit)
  );

  por_seq_state state_i (
    .clk(clk), .arst(por_in), .run(mclr_s), .hit(tmo_hit),
    .flag_clr(por_flag_clr), .rst_q(rst_q), .tmo_q(tmo_pulse), .flag_q(por_flag)
  );

  assign rst_out = rst_q | ~mclr_s;
endmodule

module por_reset_seq_chk #(
  parameter int unsigned TMO_TICKS = 8,
  parameter int unsigned CW        = 4
) (
  input logic          clk,
  input logic          por_in,
  input logic          mclr_s,
  input logic [CW-1:0] cnt_q,
  input logic          rst_q,
  input logic          tmo_pulse,
  input logic          por_flag,
  input logic          por_flag_clr
);
  localparam logic [CW-1:0] TERM = CW'(TMO_TICKS);

  AST_LOW_SETS_LATCH: assert property (@(posedge clk) disable iff (por_in)
    !mclr_s |=> (rst_q && cnt_q == '0)); // R4
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (por_in)
    tmo_pulse |=> !tmo_pulse); // R5
  AST_RELEASE_MARKED: assert property (@(posedge clk) disable iff (por_in)
    $fell(rst_q) |-> tmo_pulse); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (por_in)
    cnt_q <= TERM); // R6
  AST_HOLD_AT_TERM: assert property (@(posedge clk) disable iff (por_in)
    (cnt_q == TERM && mclr_s) |=> (cnt_q == TERM && !rst_q && !tmo_pulse)); // R6
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (por_in)
    por_flag_clr |=> !por_flag); // R7
  AST_FLAG_STAYS_LOW: assert property (@(posedge clk) disable iff (por_in)
    !por_flag |=> !por_flag); // R7
endmodule

bind por_reset_seq por_reset_seq_chk #(.TMO_TICKS(TMO_TICKS), .CW(CW)) chk_i (
  .clk(clk), .por_in(por_in), .mclr_s(mclr_s), .cnt_q(cnt_q), .rst_q(rst_q),
  .tmo_pulse(tmo_pulse), .por_flag(por_flag), .por_flag_clr(por_flag_clr)
);

// File: tb/por_reset_seq_tb_top.sv
`timescale 1ns/1ps
module por_reset_seq_tb_top;
  localparam int TMO  = 5;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + TMO - 1; // 0-based edge index of release

  logic clk = 1'b0;
  logic por_in = 1'b1;
  logic mclr_n = 1'b0;
  logic por_flag_clr = 1'b0;
  logic rst_out, tmo_pulse, por_flag;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  por_reset_seq #(.TMO_TICKS(TMO), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .por_in(por_in), .mclr_n(mclr_n), .por_flag_clr(por_flag_clr),
    .rst_out(rst_out), .tmo_pulse(tmo_pulse), .por_flag(por_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_por(input logic mclr_level);
    @(negedge clk);
    por_in = 1'b1;
    mclr_n = mclr_level;
    step();
    step();
    por_in = 1'b0;
  endtask

  // mclr_n must already be high; counts edges from the next one
  task automatic measure(output int first_low, output int pulses, output int pulse_at);
    first_low = -1; pulses = 0; pulse_at = -1;
    for (int k = 0; k < LAT + 6; k++) begin
      step();
      if (rst_out == 1'b0 && first_low < 0) first_low = k;
      if (tmo_pulse) begin pulses++; pulse_at = k; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int fl, np, pa, bad;
    // R1: reset state while power-on is high, pin low then high
    step(); step(); step();
    check(rst_out == 1'b1, "R1 rst_out", rst_out, 1);
    check(tmo_pulse == 1'b0, "R1 tmo_pulse", tmo_pulse, 0);
    check(por_flag == 1'b1, "R1 por_flag", por_flag, 1);
    mclr_n = 1'b1; por_flag_clr = 1'b1;
    step(); step(); step(); step();
    check(rst_out == 1'b1, "R1 rst_out with pin high", rst_out, 1);
    check(por_flag == 1'b1, "R1 flag clear ignored", por_flag, 1);
    por_flag_clr = 1'b0; mclr_n = 1'b0;
    step();

    // R2: falling power-on alone does not release
    por_in = 1'b0;
    bad = 0;
    for (int k = 0; k < 20; k++) begin step(); if (rst_out != 1'b1) bad++; end
    check(bad == 0, "R2 held in reset", bad, 0);

    // R3/R5: release latency and pulse
    mclr_n = 1'b1;
    measure(fl, np, pa);
    check(fl == LAT, "R3 release edge", fl, LAT);
    check(np == 1, "R5 pulse count", np, 1);
    check(pa == fl, "R5 pulse cycle", pa, fl);

    // R6: no wrap
    bad = 0;
    for (int k = 0; k < 4 * TMO + 10; k++) begin
      step(); if (rst_out != 1'b0 || tmo_pulse != 1'b0) bad++;
    end
    check(bad == 0, "R6 stays released", bad, 0);
    check(por_flag == 1'b1, "R7 flag survives time-out", por_flag, 1);

    // R7: software clear
    por_flag_clr = 1'b1; step(); por_flag_clr = 1'b0;
    check(por_flag == 1'b0, "R7 flag cleared", por_flag, 0);
    step(); step(); step();
    check(por_flag == 1'b0, "R7 flag stays clear", por_flag, 0);

    // R4: pin drop after time-out
    mclr_n = 1'b0;
    step();
    check(rst_out == 1'b0, "R4 before sync edge", rst_out, 0);
    step();
    check(rst_out == 1'b1, "R4 reset at sync edge", rst_out, 1);

    // R4: partial count then restart from zero
    step(); step();
    mclr_n = 1'b1;
    step(); step(); step();
    mclr_n = 1'b0;
    bad = 0;
    for (int k = 0; k < 6; k++) begin step(); if (rst_out != 1'b1) bad++; end
    check(bad == 0, "R4 held while low", bad, 0);
    mclr_n = 1'b1;
    measure(fl, np, pa);
    check(fl == LAT, "R4 full delay after restart", fl, LAT);

    // R8: sweep pin-high length across the expiry edge
    for (int n = 1; n <= TMO + 3; n++) begin
      int lows;
      do_por(1'b0);
      step(); step();
      mclr_n = 1'b1;
      np = 0; lows = 0;
      for (int k = 0; k < LAT + 6; k++) begin
        step();
        if (rst_out == 1'b0) lows++;
        if (tmo_pulse) np++;
        if (k == n - 1) mclr_n = 1'b0;
      end
      check(np == ((n >= TMO) ? 1 : 0), "R8 pulse vs length", np, (n >= TMO) ? 1 : 0);
      check((lows > 0) == (n >= TMO + 1), "R8 release vs length", lows, (n >= TMO + 1) ? 1 : 0);
      check(rst_out == 1'b1, "R8 reset after drop", rst_out, 1);
    end

    // R7/R5: flag clear on the expiry edge
    do_por(1'b0);
    step();
    mclr_n = 1'b1;
    np = 0; pa = -1;
    for (int k = 0; k < LAT + 4; k++) begin
      step();
      por_flag_clr = (k == LAT - 1);
      if (tmo_pulse) begin np++; pa = k; end
    end
    por_flag_clr = 1'b0;
    check(pa == LAT, "R5 pulse with concurrent clear", pa, LAT);
    check(por_flag == 1'b0, "R7 clear on expiry edge", por_flag, 0);

    // R9: power-on while running is immediate
    @(negedge clk);
    por_in = 1'b1;
    #1;
    check(rst_out == 1'b1, "R9 immediate reset", rst_out, 1);
    check(por_flag == 1'b1, "R9 flag set", por_flag, 1);
    @(negedge clk);
    por_in = 1'b0;
    measure(fl, np, pa);
    check(fl == LAT, "R9 full delay after power-on", fl, LAT);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule